// File: doc/BRIEF.md
# Gated Prescaled Period Timer

A 16-bit up-counter with a programmable period. It counts one of three sources: every system clock cycle, every system clock cycle while an external gate level is high, or rising edges on an external count input. The chosen source first passes through a prescaler that divides it by 1, 8, 64 or 256. When the counter advances from the period value, it wraps to zero and sets a sticky interrupt flag. In gated accumulation mode, the flag is also set when the gate input falls. Firmware can then read how long the gate was held high.

The external count input has two paths. The synchronised path passes the input through a two-stage synchroniser before edge detection. The unsynchronised path detects edges directly on the raw pin, which gives the shortest latency. All control and status pins are plain levels or single-cycle pulses. The block has no streaming data interface and no back-pressure.

Top module: `prd_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `count` is 0 and `irq_flag` is 0.
- R2: With `cfg_ext_src`=0, `cfg_gate_mode`=0 and `cfg_div_sel`=00, the counter advances by one on every clock edge while `cfg_enable` is 1. An advance made while `count` equals `period` loads 0 instead of `period`+1.
- R3: An advance made while `count` equals `period` sets `irq_flag`. The flag stays set until `flag_clr` is high at a clock edge. When a set and a clear fall on the same edge, the set wins.
- R4: The prescaler ratio is selected by `cfg_div_sel`: 00 divides by 1, 01 by 8, 10 by 64 and 11 by 256. With ratio N, the first advance comes on the Nth source tick after enabling.
- R5: The prescaler count returns to zero on any edge where `cnt_wr` is high, `cfg_enable` is low, or `cfg_div_sel` differs from its value on the previous edge. The source tick on that edge is discarded.
- R6: A `cnt_wr` pulse loads `cnt_wdata` into `count` on the next edge and takes priority over an advance on that edge.
- R7: While `cfg_enable` is 0 and no write occurs, `count` holds its value.
- R8: With `cfg_ext_src`=0 and `cfg_gate_mode`=1, a system tick is counted only while the synchronised gate is high. The gate passes through two stages, so a gate held high for H cycles produces exactly H advances at ratio 1.
- R9: In gated mode, a falling gate sets `irq_flag` on the third edge after the gate is seen low. Outside gated mode, the gate input changes neither `count` nor `irq_flag`.
- R10: With `cfg_ext_src`=1 and `cfg_sync_ext`=1, a rising edge on `ext_clk_in` is counted on the third clock edge after it is first sampled high.
- R11: With `cfg_ext_src`=1 and `cfg_sync_ext`=0, a rising edge on `ext_clk_in` is counted on the first clock edge that samples it high.
- R12: With `cfg_ext_src`=1, the external input is the count source whatever the value of `cfg_gate_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Run/stop |
| cfg_ext_src | input | 1 | 1 selects the external count input |
| cfg_gate_mode | input | 1 | 1 selects gated accumulation when the source is internal |
| cfg_sync_ext | input | 1 | 1 routes the external input through the synchroniser |
| cfg_div_sel | input | 2 | Prescaler select: 00=1, 01=8, 10=64, 11=256 |
| period | input | 16 | Wrap value |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| ext_clk_in | input | 1 | External count input |
| gate_in | input | 1 | Gate level |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| count | output | 16 | Counter value |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Each result has a fixed latency in clock edges, counted from the edge that first samples the stimulus:
- Internal ticks and counter writes: one edge.
- Raw external edges: one edge.
- Synchronised external edges: three edges.
- Gate rise: the first count comes on the third edge.
- Gate fall: the flag is set on the third edge.
- Prescaled advances: N edges at ratio N.

The driver records the cycle number when it applies a stimulus. It queues each expected value with its due cycle, computed from these latencies. The monitor compares only at the falling clock edge of exactly that cycle. Each check is also paired with a sample one cycle earlier, so a design that responds early or late fails.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int PRE_W = 8;  // enough for the largest ratio, 256

  typedef enum logic [1:0] {
    DIV_1   = 2'b00,
    DIV_8   = 2'b01,
    DIV_64  = 2'b10,
    DIV_256 = 2'b11
  } div_sel_e;

  // terminal value of the prescale counter for a given select
  function automatic logic [PRE_W-1:0] div_last(div_sel_e s);
    case (s)
      DIV_8:   div_last = PRE_W'(7);
      DIV_64:  div_last = PRE_W'(63);
      DIV_256: div_last = PRE_W'(255);
      default: div_last = '0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_src.sv
// Source selection: synchronisers, edge detection, gate qualification.
module tmr_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sel_ext,
  input  logic sel_gate,
  input  logic sel_sync,
  input  logic ext_clk_in,
  input  logic gate_in,
  output logic src_tick,
  output logic gate_fall
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] ext_sh;
  logic [SH_W-1:0] gate_sh;
  logic            raw_prev;
  logic            ext_rise_sync, ext_rise_raw, ext_tick;
  logic            gate_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_sh   <= '0;
      gate_sh  <= '0;
      raw_prev <= 1'b0;
    end else begin
      ext_sh   <= {ext_sh[SH_W-2:0], ext_clk_in};
      gate_sh  <= {gate_sh[SH_W-2:0], gate_in};
      raw_prev <= ext_clk_in;
    end
  end

  // synchronised edge: last sync stage high, history stage low
  assign ext_rise_sync = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];
  // raw edge: pin high now, low on the previous edge
  assign ext_rise_raw  = ext_clk_in & ~raw_prev;

  generate
    if (SYNC_STAGES > 0) begin : g_sel
      assign ext_tick = sel_sync ? ext_rise_sync : ext_rise_raw;
    end else begin : g_raw
      assign ext_tick = ext_rise_raw;
    end
  endgenerate

  assign gate_lvl  = gate_sh[SYNC_STAGES-1];
  assign src_tick  = enable & (sel_ext ? ext_tick : (sel_gate ? gate_lvl : 1'b1));
  assign gate_fall = enable & ~sel_ext & sel_gate
                     & gate_sh[SYNC_STAGES] & ~gate_sh[SYNC_STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
// Divides the source tick by 1, 8, 64 or 256.
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       clear,
  input  logic [1:0] div_sel,
  output logic       tick_out
);
  logic [PRE_W-1:0] pcnt;
  logic [1:0]       sel_q;
  logic [PRE_W-1:0] last;
  logic             clr_all;

  assign last     = div_last(div_sel_e'(div_sel));
  assign clr_all  = clear | (div_sel != sel_q);
  assign tick_out = tick_in & ~clr_all & (pcnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt  <= '0;
      sel_q <= 2'b00;
    end else begin
      sel_q <= div_sel;
      if (clr_all)       pcnt <= '0;
      else if (tick_out) pcnt <= '0;
      else if (tick_in)  pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count.sv
// Counter, period compare and sticky flag.
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             gate_fall,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] period,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             flag
);
  logic at_period, wrap_hit, flag_set;

  assign at_period = (count == period);
  assign wrap_hit  = adv & ~wr_en & at_period;
  assign flag_set  = wrap_hit | gate_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      flag  <= 1'b0;
    end else begin
      if (wr_en)         count <= wr_data;
      else if (wrap_hit) count <= '0;
      else if (adv)      count <= count + 1'b1;

      if (flag_set)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/prd_timer.sv
module prd_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_ext_src,
  input  logic             cfg_gate_mode,
  input  logic             cfg_sync_ext,
  input  logic [1:0]       cfg_div_sel,
  input  logic [CNT_W-1:0] period,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ext_clk_in,
  input  logic             gate_in,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             irq_flag
);
  logic src_tick, gate_fall, adv;

  tmr_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable),
    .sel_ext(cfg_ext_src), .sel_gate(cfg_gate_mode), .sel_sync(cfg_sync_ext),
    .ext_clk_in(ext_clk_in), .gate_in(gate_in),
    .src_tick(src_tick), .gate_fall(gate_fall)
  );

  tmr_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .tick_in(src_tick),
    .clear(~cfg_enable | cnt_wr), .div_sel(cfg_div_sel),
    .tick_out(adv)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .gate_fall(gate_fall),
    .wr_en(cnt_wr), .wr_data(cnt_wdata), .period(period),
    .flag_clr(flag_clr), .count(count), .flag(irq_flag)
  );
endmodule

// File: rtl/prd_timer_chk.sv
module prd_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             cfg_ext_src,
  input logic             cfg_gate_mode,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count,
  input logic             irq_flag
);
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(cnt_wdata))); // R6

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !cnt_wr) |=> $stable(count)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag); // R3

  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> ($stable(count) || count == '0 || count == CNT_W'($past(count) + 1'b1))); // R2

  AST_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_flag) && !$past(cfg_gate_mode && !cfg_ext_src)) |-> (count == '0)); // R3
endmodule

bind prd_timer prd_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ext_src(cfg_ext_src),
  .cfg_gate_mode(cfg_gate_mode), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .flag_clr(flag_clr), .count(count), .irq_flag(irq_flag)
);

// File: tb/sim_prd_timer.sv
module sim_prd_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable, cfg_ext_src, cfg_gate_mode, cfg_sync_ext;
  logic [1:0]  cfg_div_sel;
  logic [15:0] period, cnt_wdata, count;
  logic        cnt_wr, ext_clk_in, gate_in, flag_clr, irq_flag;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic [15:0] cnt;
    logic        flg;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  prd_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ext_src(cfg_ext_src),
    .cfg_gate_mode(cfg_gate_mode), .cfg_sync_ext(cfg_sync_ext),
    .cfg_div_sel(cfg_div_sel), .period(period), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .ext_clk_in(ext_clk_in), .gate_in(gate_in),
    .flag_clr(flag_clr), .count(count), .irq_flag(irq_flag)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares every queued item in its due cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (e.due != cyc || count !== e.cnt || irq_flag !== e.flg) begin
        failures++;
        $display("FAIL %s cyc=%0d due=%0d count got %0d exp %0d flag got %b exp %b",
                 e.req, cyc, e.due, count, e.cnt, irq_flag, e.flg);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_at(input int k, input logic [15:0] c, input logic f, input string r);
    exp_t e;
    e.due = cyc + k; e.cnt = c; e.flg = f; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_enable = 0; cfg_ext_src = 0; cfg_gate_mode = 0; cfg_sync_ext = 0;
    cfg_div_sel = 2'b00; period = 16'hFFFF; cnt_wr = 0; cnt_wdata = '0;
    ext_clk_in = 0; gate_in = 0; flag_clr = 0;
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) step(1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired, queue=%0d exp 0", exp_q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    expect_at(0, 16'd0, 1'b0, "R1");
    step(1);

    // R2/R3: wrap at period 5, sticky flag, clear
    period = 16'd5;
    cfg_enable = 1;
    expect_at(3, 16'd3, 1'b0, "R2");
    expect_at(5, 16'd5, 1'b0, "R2");
    expect_at(6, 16'd0, 1'b1, "R3");
    expect_at(8, 16'd2, 1'b1, "R3");
    step(10);
    flag_clr = 1;
    expect_at(1, 16'd5, 1'b0, "R3");
    step(1);
    flag_clr = 0;
    drain();

    // R3: set wins over clear on the same edge
    do_reset();
    period = 16'd3;
    cfg_enable = 1;
    expect_at(4, 16'd0, 1'b1, "R3");
    step(3);
    flag_clr = 1;
    step(1);
    flag_clr = 0;
    drain();

    // R4: ratios 8, 64, 256
    for (int s = 1; s < 4; s++) begin
      int r;
      r = (s == 1) ? 8 : (s == 2) ? 64 : 256;
      do_reset();
      cfg_div_sel = 2'(s);
      step(2);
      cfg_enable = 1;
      expect_at(r - 1, 16'd0, 1'b0, "R4");
      expect_at(r, 16'd1, 1'b0, "R4");
      expect_at(2 * r, 16'd2, 1'b0, "R4");
      drain();
    end

    // R5: select change clears the prescaler (8 -> 64)
    do_reset();
    cfg_div_sel = 2'b01;
    step(2);
    cfg_enable = 1;
    step(5);
    cfg_div_sel = 2'b10;
    expect_at(64, 16'd0, 1'b0, "R5");
    expect_at(65, 16'd1, 1'b0, "R5");
    drain();

    // R5: disable clears the prescaler
    do_reset();
    cfg_div_sel = 2'b01;
    step(2);
    cfg_enable = 1;
    step(5);
    cfg_enable = 0;
    step(2);
    cfg_enable = 1;
    expect_at(7, 16'd0, 1'b0, "R5");
    expect_at(8, 16'd1, 1'b0, "R5");
    drain();

    // R6: write priority at ratio 1
    do_reset();
    period = 16'd50;
    cfg_enable = 1;
    step(4);
    cnt_wr = 1; cnt_wdata = 16'd40;
    expect_at(1, 16'd40, 1'b0, "R6");
    expect_at(3, 16'd42, 1'b0, "R6");
    step(1);
    cnt_wr = 0;
    drain();

    // R5/R6: write clears the prescaler at ratio 8
    do_reset();
    cfg_div_sel = 2'b01;
    step(2);
    cfg_enable = 1;
    step(3);
    cnt_wr = 1; cnt_wdata = 16'd40;
    expect_at(1, 16'd40, 1'b0, "R6");
    expect_at(8, 16'd40, 1'b0, "R5");
    expect_at(9, 16'd41, 1'b0, "R5");
    step(1);
    cnt_wr = 0;
    drain();

    // R7: stop holds the count
    do_reset();
    period = 16'd100;
    cfg_enable = 1;
    step(3);
    cfg_enable = 0;
    expect_at(1, 16'd3, 1'b0, "R7");
    expect_at(4, 16'd3, 1'b0, "R7");
    drain();

    // R8/R9: gated accumulation, flag on gate fall
    do_reset();
    period = 16'd1000;
    cfg_gate_mode = 1;
    cfg_enable = 1;
    step(3);
    expect_at(0, 16'd0, 1'b0, "R8");
    gate_in = 1;
    step(10);
    gate_in = 0;
    expect_at(2, 16'd10, 1'b0, "R8");
    expect_at(3, 16'd10, 1'b1, "R9");
    expect_at(6, 16'd10, 1'b1, "R8");
    drain();

    // R9: gate ignored in plain internal mode
    do_reset();
    period = 16'd1000;
    cfg_enable = 1;
    gate_in = 1;
    expect_at(10, 16'd10, 1'b0, "R9");
    step(4);
    gate_in = 0;
    drain();

    // R10: synchronised external edges
    do_reset();
    period = 16'd1000;
    cfg_ext_src = 1; cfg_sync_ext = 1;
    cfg_enable = 1;
    step(2);
    for (int j = 0; j < 4; j++) begin
      ext_clk_in = 1;
      expect_at(2, 16'(j), 1'b0, "R10");
      expect_at(3, 16'(j + 1), 1'b0, "R10");
      step(2);
      ext_clk_in = 0;
      step(2);
    end
    drain();

    // R11: raw external edges
    do_reset();
    period = 16'd1000;
    cfg_ext_src = 1; cfg_sync_ext = 0;
    cfg_enable = 1;
    step(2);
    ext_clk_in = 1;
    expect_at(0, 16'd0, 1'b0, "R11");
    expect_at(1, 16'd1, 1'b0, "R11");
    step(2);
    ext_clk_in = 0;
    step(2);
    ext_clk_in = 1;
    expect_at(1, 16'd2, 1'b0, "R11");
    step(2);
    ext_clk_in = 0;
    drain();

    // R12: external source wins over gate mode; gate has no effect (R9)
    do_reset();
    period = 16'd1000;
    cfg_ext_src = 1; cfg_sync_ext = 1; cfg_gate_mode = 1;
    cfg_enable = 1;
    gate_in = 1;
    step(5);
    expect_at(0, 16'd0, 1'b0, "R12");
    gate_in = 0;
    expect_at(5, 16'd0, 1'b0, "R9");
    step(5);
    ext_clk_in = 1;
    expect_at(3, 16'd1, 1'b0, "R12");
    step(2);
    ext_clk_in = 0;
    drain();

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule